// File: doc/BRIEF.md
# SPI Burst Register Access Target

This block is an SPI target (mode 0) through which an external host reaches a 32-bit word-addressed register and memory space inside the chip. Each transaction opens with a four-byte header that carries an opcode, a 16-bit byte address and a word count. A data phase of whole 32-bit words follows. The block turns the data phase into single-cycle write or read requests on a simple internal bus. The address steps by four after every word, so one frame covers a run of consecutive words.

While the host shifts in the opcode byte, the target returns a status byte. This byte is the core's live interrupt status, with bit 3 carrying the SPI error summary. The target checks the framing of every transaction. Bad opcodes, frames that end too soon or run too long, and a chip select that rises partway through a byte each set a flag in a sticky error register. The host reads that register over SPI and clears flags by writing ones to them. A companion mask register decides which flags drive the SPI error interrupt.

SCLK, chip select and MOSI are brought into the system clock domain through a two-flop synchronizer. The system clock must run at least four times faster than SCLK.

Top module: `spi_burst_target`

## Requirements
- R1: Opcode byte 0x61 starts a burst write. The next header bytes are the address high byte, the address low byte and the word count. Each group of four data bytes, most significant byte first, becomes one bus write of that word.
- R2: Opcode byte 0x41 starts a burst read. After the header, MISO carries the requested words most significant byte first. The three bytes that follow the status byte are sent as zero.
- R3: The address used for each word is the header address plus 4 for each earlier word of the same frame, for both reads and writes.
- R4: A word count of 0 means 256 words, which is the largest transfer.
- R5: The first byte on MISO in every frame is the core status input ORed with bit 3 = SPI error interrupt.
- R6: Any other opcode sets error bit 20 (invalid command). The rest of that frame makes no bus write and no bus read.
- R7: In a write frame, a chip-select rise before the declared number of words sets bit 18, and the words already completed are still written. Bytes beyond the count set bit 19 and are not written.
- R8: In a read frame, clocking bytes beyond the count sets bit 17, and a chip-select rise before the count is reached sets bit 16.
- R9: A chip-select rise partway through a byte, or partway through the header, sets bit 21.
- R10: The error register sits at byte address 0x000C and holds flags at bits 21..16. The flags are sticky, and writing 1 clears a flag. A new error in the same cycle wins over a clear. Reads of this register show the SPI error interrupt at bit 1. Accesses to 0x000C and 0x0010 never appear on the internal bus.
- R11: The mask register at byte address 0x0010 holds one bit per error flag, in the same bit positions. The SPI error interrupt is the OR of the flags whose mask bit is 0. Flags that are masked still latch.
- R12: After reset, the error and mask registers are clear, MISO is low, the interrupt is low and the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| core_status | input | 8 | Live interrupt status of the core, returned as the first byte |
| bus_addr | output | 16 | Internal bus byte address |
| bus_wdata | output | DATA_W | Internal bus write data |
| bus_we | output | 1 | Internal bus write strobe, one cycle |
| bus_re | output | 1 | Internal bus read strobe, one cycle |
| bus_rdata | input | DATA_W | Internal bus read data, valid in the cycle after bus_re |
| spi_err_irq | output | 1 | SPI error interrupt (unmasked sticky flags) |

## Verification
The hardest situations to reach are frames that break off at an awkward point: a chip select that rises after three bits of a data byte, a header cut off after its second byte, and a read clocked past its count. In each case the error flags must be correct and no stray bus access may occur. The stimulus uses a bit-level SPI driver that can stop after any bit and add any number of extra bytes. Each broken frame is followed by an SPI read of the error register, then by a selective write-one-to-clear. Together these confirm that every flag is sticky and that each one can be cleared on its own. A 256-word write with a zero count then covers the length wrap.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
    localparam int          ADDR_W     = 16;
    localparam logic [7:0]  OP_WR      = 8'h61;
    localparam logic [7:0]  OP_RD      = 8'h41;
    localparam logic [15:0] ADDR_STAT  = 16'h000C;
    localparam logic [15:0] ADDR_MASK  = 16'h0010;
    localparam int          NERR       = 6;
    localparam int          ERR_LSB    = 16;
    localparam int          IRQ_BIT    = 1;
    localparam int          GS_ERR_BIT = 3;
    // error flag indices, bit ERR_LSB + index in the register
    localparam int E_RU  = 0;
    localparam int E_RO  = 1;
    localparam int E_WU  = 2;
    localparam int E_WO  = 3;
    localparam int E_INV = 4;
    localparam int E_END = 5;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HDR  = 2'd1,
        PH_DATA = 2'd2,
        PH_DROP = 2'd3
    } phase_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic rise_o,
    output logic fall_o,
    output logic cs_start_o,
    output logic cs_end_o,
    output logic sel_o,
    output logic mosi_o
);
    logic [STAGES-1:0] sck_q, csn_q, mo_q;
    logic              sck_prev_q, csn_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q      <= '0;
            csn_q      <= '1;
            mo_q       <= '0;
            sck_prev_q <= 1'b0;
            csn_prev_q <= 1'b1;
        end else begin
            sck_q      <= {sck_q[STAGES-2:0], sclk_i};
            csn_q      <= {csn_q[STAGES-2:0], cs_n_i};
            mo_q       <= {mo_q[STAGES-2:0], mosi_i};
            sck_prev_q <= sck_q[STAGES-1];
            csn_prev_q <= csn_q[STAGES-1];
        end
    end

    assign sel_o      = ~csn_q[STAGES-1];
    assign rise_o     = sel_o & sck_q[STAGES-1] & ~sck_prev_q;
    assign fall_o     = sel_o & ~sck_q[STAGES-1] & sck_prev_q;
    assign cs_start_o = ~csn_q[STAGES-1] & csn_prev_q;
    assign cs_end_o   = csn_q[STAGES-1] & ~csn_prev_q;
    assign mosi_o     = mo_q[STAGES-1];
endmodule

// File: rtl/spi_err_status.sv
module spi_err_status
    import spi_tgt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NERR-1:0] err_set_i,
    input  logic            wr_stat_i,
    input  logic            wr_mask_i,
    input  logic [NERR-1:0] wbits_i,
    output logic [NERR-1:0] st_o,
    output logic [NERR-1:0] mask_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [NERR-1:0] st;
        logic [NERR-1:0] mask;
    } reg_t;

    reg_t q, d;

    always_comb begin
        d      = q;
        d.st   = (q.st & ~(wr_stat_i ? wbits_i : '0)) | err_set_i;
        if (wr_mask_i) d.mask = wbits_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign st_o   = q.st;
    assign mask_o = q.mask;
    assign irq_o  = |(q.st & ~q.mask);

    // R10: without a clear write no flag ever drops
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat_i |=> ((q.st & $past(q.st)) == $past(q.st)));
    // R11: an unmasked new error raises the interrupt next cycle
    a_r11_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (|(err_set_i & ~q.mask)) |=> irq_o);
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_tgt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              cs_start_i,
    input  logic              cs_end_i,
    input  logic              sel_i,
    input  logic              mosi_i,
    input  logic [7:0]        gstat_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              miso_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [DATA_W-1:0] req_wdata_o,
    output logic              req_we_o,
    output logic              req_re_o,
    output logic [NERR-1:0]   err_o
);
    localparam int BPW       = DATA_W / 8;
    localparam int BIDX_W    = (BPW > 1) ? $clog2(BPW) : 1;
    localparam int CNT_W     = LEN_W + 1;
    localparam int MAX_WORDS = 1 << LEN_W;
    localparam logic [BIDX_W-1:0] LAST_BIDX = BIDX_W'(BPW - 1);

    typedef struct packed {
        phase_e              ph;
        logic [2:0]          bit_cnt;
        logic [1:0]          hdr_cnt;
        logic [7:0]          rx_sh;
        logic                is_rd;
        logic [ADDR_W-1:0]   addr;
        logic [CNT_W-1:0]    count;
        logic [CNT_W-1:0]    rx_words;
        logic [CNT_W-1:0]    tx_words;
        logic [BIDX_W-1:0]   rx_bidx;
        logic [BIDX_W-1:0]   tx_bidx;
        logic [DATA_W-1:0]   wr_word;
        logic [DATA_W-1:0]   tx_word;
        logic [7:0]          tx_sh;
        logic [1:0]          pend;
        logic                we;
        logic                re;
        logic [ADDR_W-1:0]   req_addr;
        logic [DATA_W-1:0]   wdata;
        logic [NERR-1:0]     err;
    } st_t;

    st_t q, d;
    logic [7:0]        byte_v;
    logic [DATA_W-1:0] src_w, sh_w;

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.re   = 1'b0;
        d.err  = '0;
        d.pend = {q.pend[0], 1'b0};
        byte_v = {q.rx_sh[6:0], mosi_i};
        src_w  = q.pend[1] ? rdata_i : q.tx_word;
        sh_w   = src_w << (8 * q.tx_bidx);
        if (q.pend[1]) d.tx_word = rdata_i;

        if (cs_start_i) begin
            d.ph       = PH_HDR;
            d.bit_cnt  = '0;
            d.hdr_cnt  = '0;
            d.tx_sh    = gstat_i;
            d.rx_words = '0;
            d.tx_words = '0;
            d.rx_bidx  = '0;
            d.tx_bidx  = '0;
        end else if (cs_end_i) begin
            if (q.ph != PH_IDLE) begin
                if (q.bit_cnt != 3'd0) d.err[E_END] = 1'b1;
                if (q.ph == PH_HDR && q.hdr_cnt != 2'd0) d.err[E_END] = 1'b1;
                if (q.ph == PH_DATA && q.rx_words < q.count)
                    d.err[q.is_rd ? E_RU : E_WU] = 1'b1;
            end
            d.ph    = PH_IDLE;
            d.tx_sh = '0;
        end else if (sel_i && q.ph != PH_IDLE) begin
            if (rise_i) begin
                d.rx_sh   = byte_v;
                d.bit_cnt = q.bit_cnt + 3'd1;
                if (q.bit_cnt == 3'd7) begin
                    if (q.ph == PH_HDR) begin
                        d.hdr_cnt = q.hdr_cnt + 2'd1;
                        case (q.hdr_cnt)
                            2'd0: begin
                                if (byte_v == OP_RD)      d.is_rd = 1'b1;
                                else if (byte_v == OP_WR) d.is_rd = 1'b0;
                                else begin
                                    d.ph         = PH_DROP;
                                    d.err[E_INV] = 1'b1;
                                end
                            end
                            2'd1: d.addr = {byte_v, q.addr[7:0]};
                            2'd2: d.addr = {q.addr[ADDR_W-1:8], byte_v};
                            default: begin
                                d.count = (byte_v == 8'd0) ? CNT_W'(MAX_WORDS) : CNT_W'(byte_v);
                                d.ph    = PH_DATA;
                                if (q.is_rd) begin
                                    d.re       = 1'b1;
                                    d.req_addr = q.addr;
                                    d.addr     = q.addr + ADDR_W'(4);
                                    d.pend[0]  = 1'b1;
                                end
                            end
                        endcase
                    end else if (q.ph == PH_DATA) begin
                        if (q.rx_words == q.count) begin
                            d.err[q.is_rd ? E_RO : E_WO] = 1'b1;
                        end else begin
                            d.rx_bidx = q.rx_bidx + 1'b1;
                            d.wr_word = {q.wr_word[DATA_W-9:0], byte_v};
                            if (q.rx_bidx == LAST_BIDX) begin
                                d.rx_words = q.rx_words + CNT_W'(1);
                                if (!q.is_rd) begin
                                    d.we       = 1'b1;
                                    d.req_addr = q.addr;
                                    d.wdata    = {q.wr_word[DATA_W-9:0], byte_v};
                                    d.addr     = q.addr + ADDR_W'(4);
                                end
                            end
                        end
                    end
                end
            end else if (fall_i) begin
                if (q.bit_cnt != 3'd0) begin
                    d.tx_sh = {q.tx_sh[6:0], 1'b0};
                end else if (q.ph == PH_DATA && q.is_rd && q.tx_words < q.count) begin
                    d.tx_sh   = sh_w[DATA_W-1 -: 8];
                    d.tx_bidx = q.tx_bidx + 1'b1;
                    if (q.tx_bidx == LAST_BIDX) begin
                        d.tx_words = q.tx_words + CNT_W'(1);
                        if (q.tx_words + CNT_W'(1) < q.count) begin
                            d.re       = 1'b1;
                            d.req_addr = q.addr;
                            d.addr     = q.addr + ADDR_W'(4);
                            d.pend[0]  = 1'b1;
                        end
                    end
                end else begin
                    d.tx_sh = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign miso_o      = q.tx_sh[7];
    assign req_addr_o  = q.req_addr;
    assign req_wdata_o = q.wdata;
    assign req_we_o    = q.we;
    assign req_re_o    = q.re;
    assign err_o       = q.err;

    // R1: a word request is either a write or a read, never both
    a_r1_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.we && q.re));
    // R3: after a request the running address sits one word further on
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (q.we || q.re) |-> (q.addr == q.req_addr + ADDR_W'(4)));
    // R6: a dropped frame never touches the bus
    a_r6_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_DROP) |-> (!q.we && !q.re));
    // R5: the status byte is loaded when chip select falls
    a_r5_status_first: assert property (@(posedge clk) disable iff (!rst_n)
        cs_start_i |=> (q.tx_sh == $past(gstat_i)));
endmodule

// File: rtl/spi_burst_target.sv
module spi_burst_target
    import spi_tgt_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int LEN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [7:0]        core_status,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              spi_err_irq
);
    logic rise, fall, cs_start, cs_end, sel, mosi_s;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata, stat_word, mask_word, ctrl_rdata;
    logic req_we, req_re, req_loc, irq;
    logic [NERR-1:0] err_set, st, mask;
    logic [7:0] gstat;

    typedef struct packed {
        logic              loc;
        logic [DATA_W-1:0] val;
    } lrd_t;
    lrd_t lrd_q, lrd_d;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
        .rise_o(rise), .fall_o(fall), .cs_start_o(cs_start), .cs_end_o(cs_end),
        .sel_o(sel), .mosi_o(mosi_s)
    );

    spi_frame_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall), .cs_start_i(cs_start),
        .cs_end_i(cs_end), .sel_i(sel), .mosi_i(mosi_s), .gstat_i(gstat),
        .rdata_i(ctrl_rdata), .miso_o(spi_miso), .req_addr_o(req_addr),
        .req_wdata_o(req_wdata), .req_we_o(req_we), .req_re_o(req_re), .err_o(err_set)
    );

    spi_err_status u_err (
        .clk(clk), .rst_n(rst_n), .err_set_i(err_set),
        .wr_stat_i(req_we && req_addr == ADDR_STAT),
        .wr_mask_i(req_we && req_addr == ADDR_MASK),
        .wbits_i(req_wdata[ERR_LSB +: NERR]),
        .st_o(st), .mask_o(mask), .irq_o(irq)
    );

    always_comb begin
        req_loc   = (req_addr == ADDR_STAT) || (req_addr == ADDR_MASK);
        stat_word = '0;
        stat_word[ERR_LSB +: NERR] = st;
        stat_word[IRQ_BIT] = irq;
        mask_word = '0;
        mask_word[ERR_LSB +: NERR] = mask;
        gstat = core_status;
        gstat[GS_ERR_BIT] = core_status[GS_ERR_BIT] | irq;
        lrd_d = lrd_q;
        if (req_re) begin
            lrd_d.loc = req_loc;
            lrd_d.val = (req_addr == ADDR_STAT) ? stat_word : mask_word;
        end
        ctrl_rdata = lrd_q.loc ? lrd_q.val : bus_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lrd_q <= '0;
        else        lrd_q <= lrd_d;
    end

    assign bus_addr    = req_addr;
    assign bus_wdata   = req_wdata;
    assign bus_we      = req_we & ~req_loc;
    assign bus_re      = req_re & ~req_loc;
    assign spi_err_irq = irq;
endmodule

// File: tb/sim_spi_burst_target.sv
module sim_spi_burst_target;
    import spi_tgt_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic [7:0]  core_status = 8'hC4;
    logic [31:0] bus_rdata = '0;
    logic        miso, bus_we, bus_re, irq;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;

    int total = 0, bad = 0, re_cnt = 0;
    bit done = 1'b0;
    logic [47:0] exp_q[$];
    logic [31:0] exp_st = '0, exp_mask = '0;

    spi_burst_target u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .core_status(core_status), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .spi_err_irq(irq)
    );

    function automatic logic [31:0] rd_model(input logic [15:0] a);
        return {a ^ 16'h5A5A, ~a};
    endfunction
    function automatic logic exp_irq();
        return |(exp_st & ~exp_mask);
    endfunction
    function automatic logic [31:0] exp_stat_word();
        logic [31:0] w;
        w = exp_st;
        w[1] = exp_irq();
        return w;
    endfunction
    function automatic logic [7:0] exp_gs();
        return core_status | (exp_irq() ? 8'h08 : 8'h00);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus read model: data valid in the cycle after bus_re
    always @(posedge clk) if (bus_re) bus_rdata <= rd_model(bus_addr);

    // scoreboard monitor for bus writes
    always @(negedge clk) begin
        if (bus_re) re_cnt++;
        if (bus_we) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R1: unexpected write actual=%0h expected=none", {bus_addr, bus_wdata});
            end else begin
                check("R1/R3 bus write", {16'h0, bus_addr, bus_wdata}, {16'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic spi_bit(input logic b, output logic r);
        mosi = b;
        repeat (4) @(negedge clk);
        r = miso;
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask
    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) spi_bit(tx[i], rx[i]);
    endtask
    task automatic cs_low();
        @(negedge clk); cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask
    task automatic cs_high();
        repeat (4) @(negedge clk); cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic hdr(input logic [7:0] op, input logic [15:0] a, input logic [7:0] len);
        logic [7:0] gs, d;
        spi_byte(op, gs);
        check("R5 status byte", gs, exp_gs());
        spi_byte(a[15:8], d);
        spi_byte(a[7:0], d);
        spi_byte(len, d);
        check("R2 header filler", d, 8'h00);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] len, input int nw,
                            input int extra, input logic [31:0] seed);
        logic [7:0] d;
        logic [31:0] w;
        int lw;
        lw = (len == 0) ? 256 : int'(len);
        cs_low();
        hdr(OP_WR, a, len);
        for (int k = 0; k < nw; k++) begin
            w = seed + 32'h0103_0507 * k;
            if (k < lw && a != ADDR_STAT && a != ADDR_MASK) exp_q.push_back({a + 16'(4 * k), w});
            for (int b = 3; b >= 0; b--) spi_byte(w[8*b +: 8], d);
        end
        for (int k = 0; k < extra; k++) spi_byte(8'hEE, d);
        cs_high();
    endtask

    task automatic do_read(input logic [15:0] a, input logic [7:0] len, input int nw,
                           input int extra, input string tag);
        logic [7:0] d;
        logic [31:0] w, e;
        e = '0;
        if (a == ADDR_STAT) e = exp_stat_word();
        cs_low();
        hdr(OP_RD, a, len);
        for (int k = 0; k < nw; k++) begin
            for (int b = 3; b >= 0; b--) spi_byte(8'h00, w[8*b +: 8]);
            if (a == ADDR_STAT)      check(tag, w, e);
            else if (a == ADDR_MASK) check(tag, w, exp_mask);
            else                     check(tag, w, rd_model(a + 16'(4 * k)));
        end
        for (int k = 0; k < extra; k++) spi_byte(8'h00, d);
        cs_high();
    endtask

    initial begin
        logic [7:0] d;
        logic r;
        int re0;
        repeat (5) @(negedge clk);
        // R12 reset state
        check("R12 miso", miso, 0);
        check("R12 bus idle", {bus_we, bus_re}, 0);
        check("R12 irq", irq, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        do_read(ADDR_STAT, 1, 1, 0, "R12 status clear");
        do_read(ADDR_MASK, 1, 1, 0, "R12 mask clear");
        check("R10 local read hidden", re_cnt, 0);

        // R1 R3 write burst, R2 R3 read burst
        do_write(16'h0100, 3, 3, 0, 32'hDEAD_0001);
        do_read(16'h0200, 3, 3, 0, "R2/R3 read data");
        check("R2 bus reads", re_cnt, 3);

        // R6 invalid opcode
        re0 = re_cnt;
        cs_low();
        spi_byte(8'h55, d);
        for (int k = 0; k < 7; k++) spi_byte(8'h61, d);
        cs_high();
        exp_st[20] = 1'b1;
        check("R6 no bus read", re_cnt, re0);
        check("R11 irq up", irq, 1);
        do_read(ADDR_STAT, 1, 1, 0, "R6 invalid flag");

        // R10 W1C
        do_write(ADDR_STAT, 1, 1, 0, 32'h0010_0000);
        exp_st[20] = 1'b0;
        do_read(ADDR_STAT, 1, 1, 0, "R10 cleared");

        // R7 underflow and overflow
        do_write(16'h0300, 2, 1, 0, 32'h1111_2222);
        exp_st[18] = 1'b1;
        do_write(16'h0400, 1, 1, 2, 32'h3333_4444);
        exp_st[19] = 1'b1;
        do_read(ADDR_STAT, 1, 1, 0, "R7 write flags");
        do_write(ADDR_STAT, 1, 1, 0, 32'h0004_0000);
        exp_st[18] = 1'b0;
        do_read(ADDR_STAT, 1, 1, 0, "R10 selective clear");

        // R11 mask
        do_write(ADDR_MASK, 1, 1, 0, 32'h0008_0000);
        exp_mask = 32'h0008_0000;
        check("R11 masked irq", irq, 0);
        do_read(ADDR_STAT, 1, 1, 0, "R11 masked flag latched");
        do_read(ADDR_MASK, 1, 1, 0, "R11 mask readback");

        // R8 read overflow and underflow
        do_read(16'h0500, 1, 1, 2, "R8 read data");
        exp_st[17] = 1'b1;
        do_read(16'h0600, 2, 1, 0, "R8 read data");
        exp_st[16] = 1'b1;
        check("R11 irq unmasked", irq, 1);
        do_read(ADDR_STAT, 1, 1, 0, "R8 read flags");

        // R9 header cut short, then partial byte
        cs_low();
        spi_byte(OP_WR, d);
        spi_byte(8'h07, d);
        cs_high();
        exp_st[21] = 1'b1;
        do_read(ADDR_STAT, 1, 1, 0, "R9 header cut");
        do_write(ADDR_STAT, 1, 1, 0, 32'h003F_0000);
        exp_st = '0;
        cs_low();
        hdr(OP_WR, 16'h0700, 1);
        for (int k = 0; k < 3; k++) spi_bit(1'b1, r);
        cs_high();
        exp_st[21] = 1'b1;
        exp_st[18] = 1'b1;
        do_read(ADDR_STAT, 1, 1, 0, "R9 partial byte");
        do_write(ADDR_STAT, 1, 1, 0, 32'h003F_0000);
        exp_st = '0;

        // R4 zero count = 256 words
        do_write(16'h1000, 0, 256, 0, 32'hA000_0000);
        check("R4 all 256 written", exp_q.size(), 0);
        do_read(ADDR_STAT, 1, 1, 0, "R4 no error on full burst");
        check("R12 irq low at end", irq, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule